// File: doc/BRIEF.md
# Banked GPIO Interrupt Controller with Per-Pin Priority

The controller watches 128 general-purpose input pins, grouped in four banks of 32, and turns their activity into interrupt requests for a processor. Each pin is either ignored or watched for a level or an edge. Its pending flag latches whenever that condition is seen. An enabled pending pin raises one of four processor request lines, chosen by the pin's own 2-bit priority. A dispatch register names the single pin that software should service next. Each pin's configuration also carries an idle-wake flag and a flag that hands the pin to its on-chip device function.

Software reaches the block through a simple word-wide register port. Writes take effect on the clock edge. Reads are combinational and have no side effects. Pin `p` sits in bank `p / 32` at bit `p % 32`. Two DMA trigger outputs can each follow any one of the 128 pins. Both inputs and bus signals are expected to be synchronous to `clk`. `rst` is a synchronous, active-high reset.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, every configuration word, enable mask, pending mask and device flag reads 0. `cpu_req` and `cpu_wake` are low, and the dispatch register reads 0xFFFFFFFF.
- R2: The configuration word of pin p is at byte address 4*p (0x000–0x1FC). Its fields are: trigger in bits [2:0], priority in bits [5:4], idle-wake in bit 6 and device flag in bit 7. A write replaces the whole word, bit 3 and bits [31:8] read as 0, and a readback returns exactly the stored fields.
- R3: Trigger codes are 0 off, 1 level high, 2 level low, 3 rising edge, 4 falling edge and 5 either edge. Codes 6 and 7 act as off. A qualifying input sampled at a clock edge sets the pin's pending bit at that same edge. Edges are judged against the value sampled at the previous edge.
- R4: Writing a 1 to a pin's bit of its bank pending register (bank base + 0x08) clears that pending bit. When a new trigger condition occurs in the same cycle as this write, the pending bit stays set. A pin on an active level trigger therefore cannot be cleared.
- R5: Writing ones to the enable-set register (bank base + 0x00) enables those pins, and writing ones to the enable-clear register (bank base + 0x04) disables them. Zero bits leave pins unchanged. Both addresses read back the enable mask. The bank base is 0x200 + 0x20*bank.
- R6: Pending bits latch whether or not the pin is enabled.
- R7: `cpu_req[n]` is high exactly when at least one enabled, pending pin has priority n.
- R8: The dispatch register (0x284) returns the lowest pin number among the enabled, pending pins with the numerically smallest priority. It reads 0xFFFFFFFF when no enabled pin is pending.
- R9: `cpu_wake` is high exactly when a pending pin has its idle-wake bit set. Its enable state does not matter.
- R10: Writing ones to the device-select register (bank base + 0x0C) sets the device flag of those pins, and zero bits have no effect. The register reads back the bank's device flags. The flags also appear in bit 7 of each configuration word and on `dev_sel`.
- R11: The DMA select register (0x280) holds the pin number for trigger n in bits [8n+6:8n]. A write with `bus_be[n]` set replaces byte n entirely, with bit 8n+7 reading 0, and leaves the other byte alone. `dma_trig[n]` follows the level of the selected pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gpio_in | input | 128 | Pin levels, synchronous to clk |
| bus_we | input | 1 | Register write strobe |
| bus_be | input | 4 | Byte lanes (used by the DMA select register) |
| bus_addr | input | 10 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| cpu_req | output | 4 | Request line per priority level, 0 highest |
| cpu_wake | output | 1 | Idle wake request |
| dev_sel | output | 128 | Per-pin device-function flag |
| dma_trig | output | 2 | DMA trigger lines |

## Verification
An acknowledge written to a bank pending register can land in the same clock edge as a fresh trigger event on the same pin. This matters most on edge triggers, where losing the new edge would lose an interrupt. A per-pin sweep over all eight trigger codes drives an input pattern and an acknowledge pattern together on one pin, so that several acknowledges coincide with edges or with active levels. The bench's own model, in which the event overrides the clear, then judges the pending bit after every cycle.

// File: rtl/gpic_pkg.sv
package gpic_pkg;

    typedef enum logic [2:0] {
        TRIG_OFF    = 3'd0,
        TRIG_LVL_HI = 3'd1,
        TRIG_LVL_LO = 3'd2,
        TRIG_RISE   = 3'd3,
        TRIG_FALL   = 3'd4,
        TRIG_BOTH   = 3'd5,
        TRIG_RSV6   = 3'd6,
        TRIG_RSV7   = 3'd7
    } trig_e;

    // Bit layout of one pin word: [7] dev, [6] wake, [5:4] prio, [3] zero, [2:0] trig
    typedef struct packed {
        logic       dev;
        logic       wake;
        logic [1:0] prio;
        logic       rsvd;
        trig_e      trig;
    } pin_cfg_t;

    localparam int CFG_W       = 8;
    localparam int PRIO_W      = 2;
    localparam int BANK_STRIDE = 32;
    localparam int STRIDE_SH   = 5;

    // word index inside one bank window
    localparam logic [2:0] REG_EN_SET = 3'd0;
    localparam logic [2:0] REG_EN_CLR = 3'd1;
    localparam logic [2:0] REG_PEND   = 3'd2;
    localparam logic [2:0] REG_DEV    = 3'd3;

endpackage

// File: rtl/gpic_pin.sv
module gpic_pin
    import gpic_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           pin_in,
    input  logic           cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic           en_set,
    input  logic           en_clr,
    input  logic           pend_clr,
    input  logic           dev_set,
    output pin_cfg_t       cfg_q,
    output logic           en_q,
    output logic           pend_q
);

    logic prev_q;
    logic hit;
    logic unused_rsvd;

    assign unused_rsvd = cfg_wdata[3];

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= pin_in;
    end

    always_comb begin
        unique case (cfg_q.trig)
            TRIG_OFF:    hit = 1'b0;
            TRIG_LVL_HI: hit = pin_in;
            TRIG_LVL_LO: hit = ~pin_in;
            TRIG_RISE:   hit = pin_in & ~prev_q;
            TRIG_FALL:   hit = ~pin_in & prev_q;
            TRIG_BOTH:   hit = pin_in ^ prev_q;
            TRIG_RSV6:   hit = 1'b0;
            TRIG_RSV7:   hit = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (cfg_we) begin
            cfg_q.dev  <= cfg_wdata[7];
            cfg_q.wake <= cfg_wdata[6];
            cfg_q.prio <= cfg_wdata[5:4];
            cfg_q.rsvd <= 1'b0;
            cfg_q.trig <= trig_e'(cfg_wdata[2:0]);
        end else if (dev_set) begin
            cfg_q.dev  <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         en_q <= 1'b0;
        else if (en_set) en_q <= 1'b1;
        else if (en_clr) en_q <= 1'b0;
    end

    // a new event overrides a simultaneous acknowledge
    always_ff @(posedge clk) begin
        if (rst) pend_q <= 1'b0;
        else     pend_q <= (pend_q & ~pend_clr) | hit;
    end

    AST_OFF_STAYS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.trig == TRIG_OFF && !pend_q) |=> !pend_q); // R3
    AST_LEVEL_STICKS: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.trig == TRIG_LVL_HI && pin_in) |=> pend_q); // R4

endmodule

// File: rtl/gpic_arbiter.sv
module gpic_arbiter
    import gpic_pkg::*;
#(
    parameter int NUM_PINS = 128,
    parameter int NUM_LVL  = 4,
    localparam int IDX_W   = $clog2(NUM_PINS)
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [NUM_PINS-1:0]               pend,
    input  logic [NUM_PINS-1:0]               en,
    input  logic [NUM_PINS-1:0][PRIO_W-1:0]   prio,
    output logic [NUM_LVL-1:0]                req,
    output logic                              win_valid,
    output logic [IDX_W-1:0]                  win_idx
);

    logic [IDX_W-1:0] low_all [NUM_LVL];

    for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
        logic [NUM_PINS-1:0] act;
        logic [IDX_W-1:0]    low;

        for (genvar i = 0; i < NUM_PINS; i++) begin : g_act
            assign act[i] = pend[i] & en[i] & (prio[i] == PRIO_W'(l));
        end

        always_comb begin
            low = '0;
            for (int i = NUM_PINS - 1; i >= 0; i--) begin
                if (act[i]) low = IDX_W'(i);
            end
        end

        assign req[l]     = |act;
        assign low_all[l] = low;
    end

    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        for (int l = NUM_LVL - 1; l >= 0; l--) begin
            if (req[l]) begin
                win_valid = 1'b1;
                win_idx   = low_all[l];
            end
        end
    end

    AST_WIN_IS_LIVE: assert property (@(posedge clk) disable iff (rst)
        win_valid |-> (pend[win_idx] && en[win_idx])); // R8
    AST_WIN_LINE_RAISED: assert property (@(posedge clk) disable iff (rst)
        win_valid |-> req[prio[win_idx]]); // R7
    AST_NO_EN_NO_REQ: assert property (@(posedge clk) disable iff (rst)
        (en == '0) |-> (req == '0 && !win_valid)); // R5

endmodule

// File: rtl/gpic_dma_sel.sv
module gpic_dma_sel #(
    parameter int NUM_PINS = 128,
    parameter int NUM_CH   = 2,
    parameter int DATA_W   = 32,
    localparam int IDX_W   = $clog2(NUM_PINS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                we,
    input  logic [NUM_CH-1:0]   be,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [NUM_PINS-1:0] gpio_in,
    output logic [IDX_W-1:0]    sel_q [NUM_CH],
    output logic [NUM_CH-1:0]   trig
);

    logic unused_wdata;
    assign unused_wdata = ^wdata;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst)                 sel_q[c] <= '0;
            else if (we && be[c])    sel_q[c] <= wdata[c*8 +: IDX_W];
        end

        assign trig[c] = gpio_in[sel_q[c]];

        AST_LANE_KEEP: assert property (@(posedge clk) disable iff (rst)
            (we && !be[c]) |=> $stable(sel_q[c])); // R11
    end

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpic_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int BANK_W    = 32,
    parameter int NUM_LVL   = 4,
    parameter int NUM_DMA   = 2,
    parameter int ADDR_W    = 10,
    parameter int DATA_W    = 32,
    localparam int NUM_PINS   = NUM_BANKS * BANK_W,
    localparam int IDX_W      = $clog2(NUM_PINS),
    localparam int BE_W       = DATA_W / 8,
    localparam int BANK_SEL_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] gpio_in,
    input  logic                bus_we,
    input  logic [BE_W-1:0]     bus_be,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic [NUM_LVL-1:0]  cpu_req,
    output logic                cpu_wake,
    output logic [NUM_PINS-1:0] dev_sel,
    output logic [NUM_DMA-1:0]  dma_trig
);

    localparam logic [ADDR_W-1:0] BANK_BASE = ADDR_W'(NUM_PINS * 4);
    localparam logic [ADDR_W-1:0] BANK_SPAN = ADDR_W'(NUM_BANKS * BANK_STRIDE);
    localparam logic [ADDR_W-1:0] DMA_ADDR  = BANK_BASE + BANK_SPAN;
    localparam logic [ADDR_W-1:0] DISP_ADDR = DMA_ADDR + ADDR_W'(4);

    // ---------------- address decode ----------------
    logic                  aligned;
    logic                  hit_cfg;
    logic                  hit_bank;
    logic                  hit_dma;
    logic                  hit_disp;
    logic [ADDR_W-1:0]     bank_off;
    logic [BANK_SEL_W-1:0] bank_idx;
    logic [2:0]            reg_idx;
    logic [IDX_W-1:0]      cfg_idx;

    assign aligned  = (bus_addr[1:0] == 2'b00);
    assign hit_cfg  = aligned && (bus_addr < BANK_BASE);
    assign bank_off = bus_addr - BANK_BASE;
    assign hit_bank = aligned && (bus_addr >= BANK_BASE) && (bank_off < BANK_SPAN);
    assign hit_dma  = aligned && (bus_addr == DMA_ADDR);
    assign hit_disp = aligned && (bus_addr == DISP_ADDR);
    assign bank_idx = bank_off[BANK_SEL_W+STRIDE_SH-1:STRIDE_SH];
    assign reg_idx  = bank_off[4:2];
    assign cfg_idx  = bus_addr[IDX_W+1:2];

    logic [NUM_BANKS-1:0] wr_en_set;
    logic [NUM_BANKS-1:0] wr_en_clr;
    logic [NUM_BANKS-1:0] wr_pend;
    logic [NUM_BANKS-1:0] wr_dev;
    logic                 wr_cfg;
    logic                 wr_dma;

    always_comb begin
        wr_cfg = bus_we && hit_cfg;
        wr_dma = bus_we && hit_dma;
        for (int b = 0; b < NUM_BANKS; b++) begin
            wr_en_set[b] = bus_we && hit_bank && (bank_idx == BANK_SEL_W'(b)) && (reg_idx == REG_EN_SET);
            wr_en_clr[b] = bus_we && hit_bank && (bank_idx == BANK_SEL_W'(b)) && (reg_idx == REG_EN_CLR);
            wr_pend[b]   = bus_we && hit_bank && (bank_idx == BANK_SEL_W'(b)) && (reg_idx == REG_PEND);
            wr_dev[b]    = bus_we && hit_bank && (bank_idx == BANK_SEL_W'(b)) && (reg_idx == REG_DEV);
        end
    end

    // ---------------- per-pin cells ----------------
    pin_cfg_t                          cfg_arr [NUM_PINS];
    logic [NUM_PINS-1:0]               en_vec;
    logic [NUM_PINS-1:0]               pend_vec;
    logic [NUM_PINS-1:0]               wake_vec;
    logic [NUM_PINS-1:0][PRIO_W-1:0]   prio_vec;

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        localparam int BK = i / BANK_W;
        localparam int BT = i % BANK_W;

        gpic_pin i_cell (
            .clk       (clk),
            .rst       (rst),
            .pin_in    (gpio_in[i]),
            .cfg_we    (wr_cfg && (cfg_idx == IDX_W'(i))),
            .cfg_wdata (bus_wdata[CFG_W-1:0]),
            .en_set    (wr_en_set[BK] && bus_wdata[BT]),
            .en_clr    (wr_en_clr[BK] && bus_wdata[BT]),
            .pend_clr  (wr_pend[BK]   && bus_wdata[BT]),
            .dev_set   (wr_dev[BK]    && bus_wdata[BT]),
            .cfg_q     (cfg_arr[i]),
            .en_q      (en_vec[i]),
            .pend_q    (pend_vec[i])
        );

        assign dev_sel[i]  = cfg_arr[i].dev;
        assign wake_vec[i] = cfg_arr[i].wake;
        assign prio_vec[i] = cfg_arr[i].prio;
    end

    // ---------------- priority resolution ----------------
    logic             win_valid;
    logic [IDX_W-1:0] win_idx;

    gpic_arbiter #(
        .NUM_PINS (NUM_PINS),
        .NUM_LVL  (NUM_LVL)
    ) i_arb (
        .clk       (clk),
        .rst       (rst),
        .pend      (pend_vec),
        .en        (en_vec),
        .prio      (prio_vec),
        .req       (cpu_req),
        .win_valid (win_valid),
        .win_idx   (win_idx)
    );

    assign cpu_wake = |(pend_vec & wake_vec);

    // ---------------- DMA trigger selection ----------------
    logic [IDX_W-1:0] dma_sel [NUM_DMA];

    gpic_dma_sel #(
        .NUM_PINS (NUM_PINS),
        .NUM_CH   (NUM_DMA),
        .DATA_W   (DATA_W)
    ) i_dma (
        .clk     (clk),
        .rst     (rst),
        .we      (wr_dma),
        .be      (bus_be[NUM_DMA-1:0]),
        .wdata   (bus_wdata),
        .gpio_in (gpio_in),
        .sel_q   (dma_sel),
        .trig    (dma_trig)
    );

    logic unused_be;
    assign unused_be = ^bus_be;

    // ---------------- read mux ----------------
    logic [DATA_W-1:0] dma_word;

    always_comb begin
        dma_word = '0;
        for (int c = 0; c < NUM_DMA; c++) begin
            dma_word[c*8 +: IDX_W] = dma_sel[c];
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (hit_cfg) begin
            bus_rdata = DATA_W'(cfg_arr[cfg_idx]);
        end else if (hit_bank) begin
            case (reg_idx)
                REG_EN_SET: bus_rdata = DATA_W'(en_vec[bank_idx*BANK_W +: BANK_W]);
                REG_EN_CLR: bus_rdata = DATA_W'(en_vec[bank_idx*BANK_W +: BANK_W]);
                REG_PEND:   bus_rdata = DATA_W'(pend_vec[bank_idx*BANK_W +: BANK_W]);
                REG_DEV:    bus_rdata = DATA_W'(dev_sel[bank_idx*BANK_W +: BANK_W]);
                default:    bus_rdata = '0;
            endcase
        end else if (hit_dma) begin
            bus_rdata = dma_word;
        end else if (hit_disp) begin
            bus_rdata = win_valid ? DATA_W'(win_idx) : '1;
        end
    end

    AST_WAKE_NEEDS_PEND: assert property (@(posedge clk) disable iff (rst)
        cpu_wake |-> (pend_vec != '0)); // R9

endmodule

// File: tb/test_gpio_irq_ctrl.sv
`timescale 1ns/1ps
module test_gpio_irq_ctrl;

    localparam int NP = 128;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NP-1:0] gpio_in = '0;
    logic          bus_we = 1'b0;
    logic [3:0]    bus_be = 4'hF;
    logic [9:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [3:0]    cpu_req;
    logic          cpu_wake;
    logic [NP-1:0] dev_sel;
    logic [1:0]    dma_trig;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    gpio_irq_ctrl i_gpio_irq_ctrl (
        .clk(clk), .rst(rst), .gpio_in(gpio_in), .bus_we(bus_we), .bus_be(bus_be),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cpu_req(cpu_req), .cpu_wake(cpu_wake), .dev_sel(dev_sel), .dma_trig(dma_trig)
    );

    function automatic logic [9:0] bank_addr(int b, int r);
        return 10'(32'h200 + 32'h20 * b + 4 * r);
    endfunction

    function automatic int prio_of(int i);
        return (i * 3 + i / 7) % 4;
    endfunction

    function automatic bit exp_hit(int code, bit cur, bit prv);
        case (code)
            1: return cur;
            2: return !cur;
            3: return cur && !prv;
            4: return !cur && prv;
            5: return cur != prv;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [31:0] xs(logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [9:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
        @(negedge clk);
        bus_we = 1'b0; bus_be = 4'hF;
    endtask

    task automatic bus_read(input logic [9:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic [31:0] d;
        logic [NP-1:0] g, e, act, wk;
        logic [31:0] s;

        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        for (int i = 0; i < NP; i++) begin
            bus_read(10'(4 * i), rd);
            check($sformatf("R1 cfg %0d", i), rd, 32'h0);
        end
        for (int b = 0; b < 4; b++) begin
            for (int r = 0; r < 4; r++) begin
                bus_read(bank_addr(b, r), rd);
                check($sformatf("R1 bank %0d reg %0d", b, r), rd, 32'h0);
            end
        end
        bus_read(10'h284, rd);
        check("R1 dispatch", rd, 32'hFFFF_FFFF);
        check("R1 cpu_req", 32'(cpu_req), 32'h0);
        check("R1 cpu_wake", 32'(cpu_wake), 32'h0);
        check("R1 dev_sel", 32'(|dev_sel), 32'h0);

        // R2 / R10: config word write and readback over every pin
        for (int i = 0; i < NP; i++) begin
            d = 32'h5A5A_5A00 | 32'((i * 29 + 11) & 8'hFF);
            bus_write(10'(4 * i), d);
            bus_read(10'(4 * i), rd);
            check($sformatf("R2 cfg %0d", i), rd, d & 32'hF7);
            check($sformatf("R10 dev_sel %0d", i), 32'(dev_sel[i]), 32'(d[7]));
        end
        for (int i = 0; i < NP; i++) bus_write(10'(4 * i), 32'h0);
        for (int b = 0; b < 4; b++) bus_write(bank_addr(b, 2), 32'hFFFF_FFFF);

        // R3 / R4: trigger sweep on pin 37 (bank 1, bit 5) with coinciding acknowledges
        for (int code = 0; code < 8; code++) begin
            bit pm, pv;
            logic [11:0] pat, ackp;
            pat  = 12'b0110_1001_1100;
            ackp = 12'b0101_0010_0110;
            bus_write(10'(4 * 37), 32'h0);
            bus_write(bank_addr(1, 2), 32'hFFFF_FFFF);
            bus_write(10'(4 * 37), 32'(code));
            pm = 1'b0; pv = 1'b0;
            for (int st = 0; st < 12; st++) begin
                gpio_in[37] = pat[st];
                if (ackp[st]) begin
                    bus_we = 1'b1; bus_addr = bank_addr(1, 2); bus_wdata = 32'h20;
                end
                @(negedge clk);
                bus_we = 1'b0;
                pm = (pm & !ackp[st]) | exp_hit(code, pat[st], pv);
                pv = pat[st];
                bus_read(bank_addr(1, 2), rd);
                check($sformatf("R3 R4 code %0d step %0d", code, st), rd, 32'(pm) << 5);
            end
            gpio_in[37] = 1'b0;
        end
        bus_write(10'(4 * 37), 32'h0);
        bus_write(bank_addr(1, 2), 32'hFFFF_FFFF);

        // R5..R9: all pins level-high, rounds of level and enable patterns
        wk = '0;
        for (int i = 0; i < NP; i++) begin
            wk[i] = (i % 5 == 0);
            bus_write(10'(4 * i), 32'(1 | (prio_of(i) << 4) | ((i % 5 == 0) << 6)));
        end
        s = 32'h1234_5678;
        for (int rnd = 0; rnd < 12; rnd++) begin
            logic [3:0] ereq;
            logic [31:0] edisp;
            for (int w = 0; w < 4; w++) begin
                logic [31:0] a1, a2, a3;
                s = xs(s); a1 = s; s = xs(s); a2 = s; s = xs(s); a3 = s;
                g[w*32 +: 32] = a1 & a2 & (rnd[0] ? a3 : 32'hFFFF_FFFF);
                e[w*32 +: 32] = a3 | a1;
            end
            if (rnd == 0) begin g = '0; e = '1; end
            if (rnd == 1) begin g = '1; e = '0; end
            if (rnd == 2) begin g = '1; e = '1; end
            @(negedge clk);
            gpio_in = g;
            for (int b = 0; b < 4; b++) bus_write(bank_addr(b, 2), 32'hFFFF_FFFF);
            for (int b = 0; b < 4; b++) bus_write(bank_addr(b, 1), 32'hFFFF_FFFF);
            for (int b = 0; b < 4; b++) bus_write(bank_addr(b, 0), e[b*32 +: 32]);
            act = g & e;
            ereq = '0; edisp = 32'hFFFF_FFFF;
            for (int p = 3; p >= 0; p--) begin
                for (int i = NP - 1; i >= 0; i--) begin
                    if (act[i] && prio_of(i) == p) begin
                        ereq[p] = 1'b1; edisp = 32'(i);
                    end
                end
                if (ereq[p]) begin
                    // keep only the best level's winner: later (lower) p overwrites
                end
            end
            for (int p = 0; p < 4 && edisp == 32'hFFFF_FFFF; p++) begin end
            // recompute winner strictly by smallest priority first
            edisp = 32'hFFFF_FFFF;
            for (int p = 0; p < 4; p++) begin
                if (edisp == 32'hFFFF_FFFF) begin
                    for (int i = 0; i < NP; i++) begin
                        if (edisp == 32'hFFFF_FFFF && act[i] && prio_of(i) == p) edisp = 32'(i);
                    end
                end
            end
            for (int b = 0; b < 4; b++) begin
                bus_read(bank_addr(b, 2), rd);
                check($sformatf("R6 round %0d pend bank %0d", rnd, b), rd, g[b*32 +: 32]);
                bus_read(bank_addr(b, 0), rd);
                check($sformatf("R5 round %0d enable bank %0d", rnd, b), rd, e[b*32 +: 32]);
            end
            bus_read(10'h284, rd);
            check($sformatf("R8 round %0d dispatch", rnd), rd, edisp);
            check($sformatf("R7 round %0d cpu_req", rnd), 32'(cpu_req), 32'(ereq));
            check($sformatf("R9 round %0d cpu_wake", rnd), 32'(cpu_wake), 32'(|(g & wk)));
        end

        // R5: zero bits in enable writes leave the mask alone
        bus_read(bank_addr(0, 1), d);
        bus_write(bank_addr(0, 0), 32'h0);
        bus_write(bank_addr(0, 1), 32'h0);
        bus_read(bank_addr(0, 0), rd);
        check("R5 zero writes ignored", rd, d);
        bus_write(bank_addr(0, 1), 32'h0000_00F0);
        bus_read(bank_addr(0, 1), rd);
        check("R5 disable ones", rd, d & 32'hFFFF_FF0F);

        // R10: device select on bank 2
        bus_write(bank_addr(2, 3), 32'h8001_0F00);
        bus_read(bank_addr(2, 3), rd);
        check("R10 dev readback", rd, 32'h8001_0F00);
        check("R10 dev_sel port", dev_sel[95:64], 32'h8001_0F00);
        bus_read(10'(4 * 72), rd);
        check("R10 cfg bit7", rd, 32'(8'h80 | 1 | (prio_of(72) << 4) | ((72 % 5 == 0) << 6)));
        bus_write(bank_addr(2, 3), 32'h0);
        bus_read(bank_addr(2, 3), rd);
        check("R10 zero write ignored", rd, 32'h8001_0F00);

        // R11: DMA trigger selection
        gpio_in = '0;
        bus_write(10'h280, 32'h0000_00D3, 4'b0001);
        bus_read(10'h280, rd);
        check("R11 byte0 load", rd, 32'h0000_0053);
        bus_write(10'h280, 32'h0000_AAFF, 4'b0010);
        bus_read(10'h280, rd);
        check("R11 byte1 load keeps byte0", rd, 32'h0000_2A53);
        for (int i = 0; i < NP; i++) begin
            bus_write(10'h280, 32'(i), 4'b0001);
            gpio_in = '0; gpio_in[i] = 1'b1;
            #1;
            check($sformatf("R11 sel %0d high", i), 32'(dma_trig), 32'({i == 42, 1'b1}));
            gpio_in = ~gpio_in;
            #1;
            check($sformatf("R11 sel %0d low", i), 32'(dma_trig), 32'({i != 42, 1'b0}));
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule